// File: doc/BRIEF.md
# Dual-Mode DMA Channel Arbiter

This block decides which of up to sixteen DMA channels is serviced next. Each channel raises a request bit. The arbiter registers one winner as a grant. The grant holds until the consumer returns an accept strobe. On the cycle after that, the block arbitrates again.

Two schemes are available, and a single mode bit chooses between them at run time:

- **Fixed priority.** Each channel has a programmable 4-bit priority. The highest value wins.
- **Round robin.** Priorities are disregarded. Channels are visited from high numbers toward low, starting just below the channel that was served last.

A mode write is honoured only while every channel's active bit is clear. If any channel is active, the write is refused, the old mode stays in force, and a sticky error flag is raised.

Top module: `dma_chan_arbiter`

## Requirements
- R1: After reset, grant_valid and cfg_err are 0, the mode is fixed priority, and the round-robin search starts at the highest channel (N_CH-1).
- R2: In fixed-priority mode (mode value 0), the requesting channel with the largest priority value is granted. Channel c's priority is prio_flat[4c+3:4c], and a larger value means higher priority.
- R3: In fixed-priority mode, when two or more requesting channels share the largest priority, the highest channel number among them is granted.
- R4: In round-robin mode (mode value 1), priority values have no effect. The grant goes to the first requesting channel found scanning downward from the current search start.
- R5: In round-robin mode, accepting a grant for channel k moves the search start to k-1. Accepting channel 0 moves it to N_CH-1.
- R6: When grant_valid is low and some request is set at a clock edge, grant_valid is high after that edge. grant_valid and grant_idx then stay unchanged until the edge at which grant_accept is high, whatever the requests do meanwhile.
- R7: At the edge where grant_accept is high with a valid grant, grant_valid falls. The next grant can appear at the edge after that.
- R8: While no request is set, grant_valid stays low and the round-robin search start does not change.
- R9: A pulse on mode_wr while chan_active is all zero loads mode_wdata as the mode (0 = fixed priority, 1 = round robin). The new mode applies to the following arbitrations.
- R10: A pulse on mode_wr while any chan_active bit is set leaves the mode unchanged and sets cfg_err. cfg_err then stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N_CH | Per-channel service request |
| prio_flat | input | N_CH*PRIO_W | Packed per-channel priority values |
| chan_active | input | N_CH | Per-channel active status |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 1 | Mode to write: 0 fixed priority, 1 round robin |
| grant_accept | input | 1 | Consumer takes the current grant |
| grant_valid | output | 1 | A grant is being presented |
| grant_idx | output | CH_W | Granted channel number |
| cfg_err | output | 1 | Sticky flag for a refused mode write |

## Verification
The bench sets up priority ties in which a design that resolves ties toward low channel numbers would pick the wrong winner. In round-robin mode it gives channel 2 the top priority value, so a design that still consulted priorities would not produce the expected downward order. It makes the pointer wrap from channel 0 to channel 15, and it leaves long idle stretches to catch a pointer that drifts without requests. It changes requests while a grant is pending, which exposes a grant that does not hold. Finally, it issues a mode write while a channel is active, so a design that took the write or failed to keep the error flag would show the wrong winner or a cleared flag.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    typedef enum logic {
        ARB_FIXED = 1'b0,
        ARB_RR    = 1'b1
    } arb_mode_e;

    // Channel below ch, wrapping from 0 to n-1
    function automatic int prev_ch(input int ch, input int n);
        return (ch == 0) ? (n - 1) : (ch - 1);
    endfunction

endpackage

// File: rtl/dma_arb_fixed_pick.sv
module dma_arb_fixed_pick #(
    parameter int N_CH   = 16,
    parameter int PRIO_W = 4,
    localparam int CH_W  = $clog2(N_CH)
) (
    input  logic [N_CH-1:0]        req,
    input  logic [N_CH*PRIO_W-1:0] prio_flat,
    output logic                   found,
    output logic [CH_W-1:0]        idx
);

    logic [PRIO_W-1:0] best;

    // Ascending scan with >= lets a higher channel win a tie
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int c = 0; c < N_CH; c++) begin
            if (req[c] && (!found || prio_flat[c*PRIO_W +: PRIO_W] >= best)) begin
                found = 1'b1;
                idx   = CH_W'(c);
                best  = prio_flat[c*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/dma_arb_rr_pick.sv
module dma_arb_rr_pick #(
    parameter int N_CH  = 16,
    localparam int CH_W = $clog2(N_CH)
) (
    input  logic [N_CH-1:0] req,
    input  logic [CH_W-1:0] start,
    output logic            found,
    output logic [CH_W-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < N_CH; i++) begin
            int ch;
            ch = ((int'(start) - i) % N_CH + N_CH) % N_CH;
            if (!found && req[ch]) begin
                found = 1'b1;
                idx   = CH_W'(ch);
            end
        end
    end

endmodule

// File: rtl/dma_arb_mode_ctrl.sv
module dma_arb_mode_ctrl
    import dma_arb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  logic      wr_mode,
    input  logic      any_active,
    output arb_mode_e mode_q,
    output logic      err_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= ARB_FIXED;
            err_q  <= 1'b0;
        end else if (wr_en) begin
            if (any_active) begin
                err_q <= 1'b1;
            end else begin
                mode_q <= arb_mode_e'(wr_mode);
            end
        end
    end

    // R10: refused write keeps mode and raises the flag
    a_r10_reject_busy: assert property (@(posedge clk) disable iff (rst)
        (wr_en && any_active) |=> (err_q && mode_q == $past(mode_q)));

    // R10: flag is sticky
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

    // R9: write while idle loads the mode
    a_r9_load_idle: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !any_active) |=> (mode_q == arb_mode_e'($past(wr_mode))));

endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
    import dma_arb_pkg::*;
#(
    parameter int N_CH   = 16,
    parameter int PRIO_W = 4,
    localparam int CH_W  = $clog2(N_CH)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_CH-1:0]        req,
    input  logic [N_CH*PRIO_W-1:0] prio_flat,
    input  logic [N_CH-1:0]        chan_active,
    input  logic                   mode_wr,
    input  logic                   mode_wdata,
    input  logic                   grant_accept,
    output logic                   grant_valid,
    output logic [CH_W-1:0]        grant_idx,
    output logic                   cfg_err
);

    arb_mode_e       mode;
    logic [CH_W-1:0] rr_ptr;
    logic            fx_found, rr_found;
    logic [CH_W-1:0] fx_idx, rr_idx;
    logic            any_req;

    assign any_req = |req;

    dma_arb_mode_ctrl u_mode (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (mode_wr),
        .wr_mode    (mode_wdata),
        .any_active (|chan_active),
        .mode_q     (mode),
        .err_q      (cfg_err)
    );

    dma_arb_fixed_pick #(.N_CH(N_CH), .PRIO_W(PRIO_W)) u_fixed (
        .req       (req),
        .prio_flat (prio_flat),
        .found     (fx_found),
        .idx       (fx_idx)
    );

    dma_arb_rr_pick #(.N_CH(N_CH)) u_rr (
        .req   (req),
        .start (rr_ptr),
        .found (rr_found),
        .idx   (rr_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_valid <= 1'b0;
            grant_idx   <= '0;
            rr_ptr      <= CH_W'(N_CH - 1);
        end else if (grant_valid) begin
            if (grant_accept) begin
                grant_valid <= 1'b0;
                if (mode == ARB_RR) begin
                    rr_ptr <= CH_W'(prev_ch(int'(grant_idx), N_CH));
                end
            end
        end else if (any_req) begin
            grant_valid <= (mode == ARB_RR) ? rr_found : fx_found;
            grant_idx   <= (mode == ARB_RR) ? rr_idx : fx_idx;
        end
    end

    // R6: a pending request produces a grant at the next edge
    a_r6_grant_follows_req: assert property (@(posedge clk) disable iff (rst)
        (!grant_valid && any_req) |=> grant_valid);

    // R6: grant holds until accepted
    a_r6_grant_hold: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && !grant_accept) |=> (grant_valid && $stable(grant_idx)));

    // R7: accept retires the grant
    a_r7_accept_drop: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && grant_accept) |=> !grant_valid);

    // R8: no requests, no grant
    a_r8_idle_no_grant: assert property (@(posedge clk) disable iff (rst)
        (!grant_valid && !any_req) |=> !grant_valid);

    // R8: search start only moves on acceptance
    a_r8_ptr_still: assert property (@(posedge clk) disable iff (rst)
        !grant_valid |=> $stable(rr_ptr));

    // R2 / R4: a new grant names a channel that was requesting
    a_r2_r4_grant_requested: assert property (@(posedge clk) disable iff (rst)
        $rose(grant_valid) |-> (($past(req) >> grant_idx) & N_CH'(1)) != '0);

endmodule

// File: tb/dma_chan_arbiter_tb_top.sv
module dma_chan_arbiter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N_CH   = 16;
    localparam int PRIO_W = 4;
    localparam int CH_W   = $clog2(N_CH);

    logic                   clk = 1'b0;
    logic                   rst;
    logic [N_CH-1:0]        req;
    logic [N_CH*PRIO_W-1:0] prio_flat;
    logic [N_CH-1:0]        chan_active;
    logic                   mode_wr;
    logic                   mode_wdata;
    logic                   grant_accept;
    logic                   grant_valid;
    logic [CH_W-1:0]        grant_idx;
    logic                   cfg_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_arbiter #(.N_CH(N_CH), .PRIO_W(PRIO_W)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .req          (req),
        .prio_flat    (prio_flat),
        .chan_active  (chan_active),
        .mode_wr      (mode_wr),
        .mode_wdata   (mode_wdata),
        .grant_accept (grant_accept),
        .grant_valid  (grant_valid),
        .grant_idx    (grant_idx),
        .cfg_err      (cfg_err)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_prio(input int ch, input int val);
        prio_flat[ch*PRIO_W +: PRIO_W] = PRIO_W'(val);
    endtask

    task automatic req_only(input int a, input int b, input int c);
        req = '0;
        if (a >= 0) req[a] = 1'b1;
        if (b >= 0) req[b] = 1'b1;
        if (c >= 0) req[c] = 1'b1;
    endtask

    // Wait for a grant, check its channel, accept it, check it retires
    task automatic serve(input string tag, input int exp);
        for (int w = 0; w < 4 && !grant_valid; w++) tick();
        check({tag, " valid"}, int'(grant_valid), 1);
        check({tag, " idx"}, int'(grant_idx), exp);
        grant_accept = 1'b1;
        tick();
        grant_accept = 1'b0;
        check("R7 grant drops after accept", int'(grant_valid), 0);
    endtask

    task automatic write_mode(input logic m);
        mode_wr    = 1'b1;
        mode_wdata = m;
        tick();
        mode_wr    = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        check("R1 grant_valid after reset", int'(grant_valid), 0);
        check("R1 cfg_err after reset", int'(cfg_err), 0);
    endtask

    task automatic t_fixed();
        prio_flat = '0;
        set_prio(3, 9); set_prio(7, 5); set_prio(12, 2);
        req_only(3, 7, 12);
        tick();
        serve("R1 R2 fixed by default, highest priority", 3);
        req_only(7, 12, -1);
        serve("R2 next highest priority", 7);
        prio_flat = '0;
        req_only(2, 5, 9);
        serve("R3 tie goes to higher channel", 9);
        set_prio(4, 6); set_prio(11, 6);
        req_only(4, 11, 1);
        serve("R3 tie at nonzero priority", 11);
        req = '0;
    endtask

    task automatic t_hold_idle();
        prio_flat = '0;
        set_prio(10, 15);
        req_only(5, -1, -1);
        tick();
        check("R6 grant one edge after request", int'(grant_valid), 1);
        req_only(10, -1, -1);
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R6 grant held while not accepted", int'(grant_idx), 5);
            check("R6 valid held while not accepted", int'(grant_valid), 1);
        end
        serve("R6 held grant", 5);
        tick();
        check("R7 next grant one edge later", int'(grant_valid), 1);
        serve("R7 re-arbitrated grant", 10);
        req = '0;
        for (int i = 0; i < 5; i++) begin
            tick();
            check("R8 no grant without requests", int'(grant_valid), 0);
        end
    endtask

    task automatic t_round_robin();
        chan_active = '0;
        write_mode(1'b1);
        check("R9 idle mode write no error", int'(cfg_err), 0);
        prio_flat = '0;
        set_prio(2, 15);
        req_only(2, 9, 12);
        tick();
        serve("R1 R4 R9 rr starts at top", 12);
        serve("R4 R5 rr downward", 9);
        serve("R4 rr ignores priority", 2);
        req_only(0, 15, -1);
        serve("R5 rr continues below 2", 0);
        serve("R5 rr wraps 0 to 15", 15);
        req = '0;
        for (int i = 0; i < 6; i++) tick();
        check("R8 rr idle no grant", int'(grant_valid), 0);
        req = '1;
        serve("R8 pointer kept across idle", 14);
        req = '0;
    endtask

    task automatic t_busy_write();
        prio_flat = '0;
        set_prio(3, 15);
        chan_active = 16'h0008;
        write_mode(1'b0);
        check("R10 refused write flags error", int'(cfg_err), 1);
        chan_active = '0;
        req_only(3, 8, -1);
        serve("R10 mode kept as rr", 8);
        req = '0;
        tick();
        check("R10 error stays set", int'(cfg_err), 1);
        write_mode(1'b0);
        req_only(3, 8, -1);
        serve("R9 switch back to fixed", 3);
        check("R10 error sticky after good write", int'(cfg_err), 1);
        req = '0;
    endtask

    initial begin
        rst = 1'b1; req = '0; prio_flat = '0; chan_active = '0;
        mode_wr = 1'b0; mode_wdata = 1'b0; grant_accept = 1'b0;
        @(negedge clk);
        t_reset();
        t_fixed();
        t_hold_idle();
        t_round_robin();
        t_busy_write();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule